// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block drives a slow triangular frequency-offset word. A fractional-N divider or a digitally controlled oscillator adds that word to its nominal setting, which sweeps a clock across a narrow band and lowers the peak of its emitted spectrum. The word is signed, and one unit is 0.001 percent of the nominal frequency. One modulation period lasts 1024 reference-clock cycles. The shape and the rate of the sweep are fixed. A 2-bit depth select chooses one of three symmetric center-spread depths or a one-sided down spread.

The enable and select pins are asynchronous to the block, so both pass through a two-stage synchroniser. A new depth takes effect only at the start of a modulation period, so the word never jumps in the middle of a sweep. While spreading is disabled, the word is zero and the clock that uses it runs at its nominal frequency. Re-enabling starts a fresh period from zero.

Top module: `ssm_profile_gen`

## Requirements
- R1: While `rst` is high, `offset_o` is 0 and both flags are 0. The synchronised controls reset to "enabled, down spread". The first cycle after `rst` falls is therefore the start of a down-spread period, whatever the pins hold.
- R2: `depth_sel` = 2'b00 selects center spread of ±0.625 %. The offset reaches +625 at phase 256 and −625 at phase 768.
- R3: `depth_sel` = 2'b01 selects ±1250 and 2'b10 selects ±2500, with the peaks at the same phases as in R2.
- R4: `depth_sel` = 2'b11 selects down spread. The offset starts at 0, reaches −3750 at phase 512 and returns toward 0. It is never positive.
- R5: A period lasts exactly 1024 cycles. `period_start_o` is high only at phase 0, where phase counts the cycles since the last period start.
- R6: For a center depth with amplitude A, the offset at phase p is sign(s)·⌊A·|s|/256⌋. Here s = p for p<256, s = 512−p for 256≤p<768, and s = p−1024 otherwise. For down spread the offset is −⌊3750·t/512⌋, with t = p for p<512 and t = 1024−p otherwise.
- R7: While spreading is disabled (`spread_n` high after synchronisation), `offset_o` is 0 and both flags are 0. Changes on `depth_sel` during that time have no visible effect.
- R8: When spreading turns on, the first active cycle is a period start at phase 0, with `offset_o` = 0 and `spread_on_o` = 1.
- R9: A change on `depth_sel` inside a period leaves the rest of that period at the old depth. The new depth applies from the next period start.
- R10: A change on `spread_n` becomes visible on the outputs after the third rising clock edge that follows it. After the second edge the outputs still show the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| spread_n | input | 1 | Spread enable, active low |
| depth_sel | input | 2 | Spread depth select (00/01/10 center, 11 down) |
| offset_o | output | 16 | Signed frequency offset, 0.001 % per unit |
| period_start_o | output | 1 | High on the first cycle of each modulation period |
| spread_on_o | output | 1 | High while modulation is running |

## Verification
Each output is due at a fixed number of clock edges after its stimulus:
- A change on `spread_n` appears after exactly three rising edges, and the bench samples at the falling edge after the second edge and again after the third, so both sides of R10 are checked.
- Once a period starts, the bench counts falling edges to track the phase and compares every sample against the R6 formula.
- A mid-period depth change is checked twice: the rest of the current period must still match the old depth, and the peak of the following period must match the new one.
- Inputs are driven right after a falling edge, and outputs are sampled at falling edges only.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        DEPTH_NARROW = 2'b00,
        DEPTH_MID    = 2'b01,
        DEPTH_WIDE   = 2'b10,
        DEPTH_DOWN   = 2'b11
    } depth_e;

    typedef struct packed {
        logic   en;
        depth_e depth;
    } ctrl_t;

    // Undriven-pin defaults: spreading on, down spread.
    localparam ctrl_t CTRL_RST = '{en: 1'b1, depth: DEPTH_DOWN};

    localparam int AMP_NARROW = 625;
    localparam int AMP_MID    = 1250;
    localparam int AMP_WIDE   = 2500;
    localparam int AMP_DOWN   = 3750;

    function automatic int depth_amp(depth_e d);
        case (d)
            DEPTH_NARROW: return AMP_NARROW;
            DEPTH_MID:    return AMP_MID;
            DEPTH_WIDE:   return AMP_WIDE;
            default:      return AMP_DOWN;
        endcase
    endfunction

endpackage

// File: rtl/ssm_sync.sv
module ssm_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ssm_phase_ctl.sv
module ssm_phase_ctl
    import ssm_pkg::*;
#(
    parameter int PHASE_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               run_o,
    output depth_e             depth_o
);
    localparam logic [PHASE_W-1:0] LAST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= '0;
            run_o   <= 1'b0;
            depth_o <= DEPTH_DOWN;
        end else if (!ctrl_i.en) begin
            phase_o <= '0;
            run_o   <= 1'b0;
        end else begin
            run_o <= 1'b1;
            if (!run_o) phase_o <= '0;
            else        phase_o <= phase_o + 1'b1;
            // depth is taken only when the next cycle is a period start
            if (!run_o || phase_o == LAST) depth_o <= ctrl_i.depth;
        end
    end
endmodule

// File: rtl/ssm_wave.sv
module ssm_wave
    import ssm_pkg::*;
#(
    parameter int PHASE_W = 10,
    parameter int OFS_W   = 16
) (
    input  logic                    run_i,
    input  logic [PHASE_W-1:0]      phase_i,
    input  depth_e                  depth_i,
    output logic signed [OFS_W-1:0] offset_o
);
    localparam int QW = PHASE_W - 2;
    localparam logic [PHASE_W-1:0] HALF    = PHASE_W'(2 ** (PHASE_W - 1));
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(2 ** QW);

    logic [PHASE_W-1:0] mag;
    logic               neg;
    int                 amp;
    int                 shift;
    int                 scaled;
    int                 ofs;

    always_comb begin
        amp   = depth_amp(depth_i);
        neg   = 1'b0;
        mag   = '0;
        shift = QW;
        if (depth_i == DEPTH_DOWN) begin
            neg   = 1'b1;
            shift = QW + 1;
            if (phase_i[PHASE_W-1]) mag = HALF - {1'b0, phase_i[PHASE_W-2:0]};
            else                    mag = {1'b0, phase_i[PHASE_W-2:0]};
        end else begin
            neg = phase_i[PHASE_W-1];
            if (phase_i[PHASE_W-2]) mag = QUARTER - {2'b00, phase_i[QW-1:0]};
            else                    mag = {2'b00, phase_i[QW-1:0]};
        end
        scaled = (amp * int'(mag)) >> shift;
        if (!run_i)   ofs = 0;
        else if (neg) ofs = -scaled;
        else          ofs = scaled;
        offset_o = OFS_W'(ofs);
    end
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
    import ssm_pkg::*;
#(
    parameter int PHASE_W = 10,
    parameter int OFS_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spread_n,
    input  logic [1:0]              depth_sel,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    period_start_o,
    output logic                    spread_on_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t              ctrl_raw;
    ctrl_t              ctrl_syn;
    logic [PHASE_W-1:0] phase;
    logic               run;
    depth_e             act_depth;

    assign ctrl_raw.en    = ~spread_n;
    assign ctrl_raw.depth = depth_e'(depth_sel);

    ssm_sync #(
        .W       (CTRL_W),
        .STAGES  (2),
        .RST_VAL (CTRL_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ctrl_raw),
        .q_o (ctrl_syn)
    );

    ssm_phase_ctl #(.PHASE_W(PHASE_W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_i  (ctrl_syn),
        .phase_o (phase),
        .run_o   (run),
        .depth_o (act_depth)
    );

    ssm_wave #(.PHASE_W(PHASE_W), .OFS_W(OFS_W)) u_wave (
        .run_i    (run),
        .phase_i  (phase),
        .depth_i  (act_depth),
        .offset_o (offset_o)
    );

    assign period_start_o = run && (phase == '0);
    assign spread_on_o    = run;
endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk #(
    parameter int PHASE_W = 10,
    parameter int OFS_W   = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic signed [OFS_W-1:0] offset_i,
    input logic                    start_i,
    input logic                    on_i,
    input logic [1:0]              depth_i
);
    localparam logic [PHASE_W:0] PERIOD = (PHASE_W+1)'(2 ** PHASE_W);

    logic [PHASE_W:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !on_i) cnt_q <= '0;
        else if (start_i) cnt_q <= (PHASE_W+1)'(1);
        else              cnt_q <= cnt_q + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!on_i && offset_i == 0 && !start_i));

    a_r7_zero_when_off: assert property (@(posedge clk) disable iff (rst)
        !on_i |-> (offset_i == 0 && !start_i));

    a_r4_down_nonpos: assert property (@(posedge clk) disable iff (rst)
        (on_i && depth_i == 2'b11) |-> (offset_i <= 0));

    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        (offset_i <= 2500 && offset_i >= -3750));

    a_r9_depth_hold: assert property (@(posedge clk) disable iff (rst)
        (on_i && !start_i) |-> $stable(depth_i));

    a_r5_period_len: assert property (@(posedge clk) disable iff (rst)
        (on_i && cnt_q == PERIOD) |-> start_i);

    a_r5_no_early: assert property (@(posedge clk) disable iff (rst)
        (start_i && cnt_q != 0) |-> (cnt_q == PERIOD));

    a_r8_fresh_start: assert property (@(posedge clk) disable iff (rst)
        $rose(on_i) |-> (start_i && offset_i == 0));
endmodule

bind ssm_profile_gen ssm_profile_chk #(.PHASE_W(PHASE_W), .OFS_W(OFS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .offset_i (offset_o),
    .start_i  (period_start_o),
    .on_i     (spread_on_o),
    .depth_i  (act_depth)
);

// File: tb/test_ssm_profile_gen.sv
module test_ssm_profile_gen;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               spread_n = 1'b0;
    logic [1:0]         depth_sel = 2'b00;
    logic signed [15:0] offset_o;
    logic               period_start_o;
    logic               spread_on_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ssm_profile_gen i_ssm_profile_gen (
        .clk            (clk),
        .rst            (rst),
        .spread_n       (spread_n),
        .depth_sel      (depth_sel),
        .offset_o       (offset_o),
        .period_start_o (period_start_o),
        .spread_on_o    (spread_on_o)
    );

    // row: select, expected max, expected min
    localparam int VEC [4][3] = '{
        '{0,  625,  -625},
        '{1, 1250, -1250},
        '{2, 2500, -2500},
        '{3,    0, -3750}
    };

    function automatic int exp_ofs(int sel, int p);
        int amp, s, m, v, t;
        if (sel == 3) begin
            t = (p < 512) ? p : 1024 - p;
            return -((3750 * t) / 512);
        end
        amp = (sel == 0) ? 625 : (sel == 1) ? 1250 : 2500;
        s = (p < 256) ? p : (p < 768) ? 512 - p : p - 1024;
        m = (s < 0) ? -s : s;
        v = (amp * m) / 256;
        return (s < 0) ? -v : v;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R10 / R8: disable, set select, enable; ends at phase 0 of a new period
    task automatic fresh_start(int sel);
        spread_n = 1'b1;
        repeat (4) tick();
        depth_sel = 2'(sel);
        repeat (3) tick();
        spread_n = 1'b0;
        repeat (2) tick();
        chk("R10", "on after two edges", int'(spread_on_o), 0);
        tick();
        chk("R8", "start flag on enable", int'(period_start_o), 1);
        chk("R8", "offset on enable", int'(offset_o), 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        int mx, mn, mism, starts;

        // R1: reset state, then default down spread first period
        repeat (5) tick();
        chk("R1", "offset in reset", int'(offset_o), 0);
        chk("R1", "on in reset", int'(spread_on_o), 0);
        chk("R1", "start in reset", int'(period_start_o), 0);
        rst = 1'b0;
        tick();
        chk("R1", "start after reset", int'(period_start_o), 1);
        repeat (512) tick();
        chk("R1", "default down minimum", int'(offset_o), -3750);
        repeat (512) tick();
        chk("R5", "second period start", int'(period_start_o), 1);
        repeat (256) tick();
        chk("R2", "select 00 adopted at boundary", int'(offset_o), 625);

        // table: every select over a full period
        for (int r = 0; r < 4; r++) begin
            fresh_start(VEC[r][0]);
            mx = -100000; mn = 100000; mism = 0; starts = 0;
            for (int p = 0; p < 1024; p++) begin
                v = int'(offset_o);
                if (v != exp_ofs(VEC[r][0], p)) mism++;
                if (v > mx) mx = v;
                if (v < mn) mn = v;
                if (period_start_o) starts++;
                tick();
            end
            chk("R6", $sformatf("profile mismatches sel=%0d", VEC[r][0]), mism, 0);
            chk(r == 3 ? "R4" : (r == 0 ? "R2" : "R3"), $sformatf("max sel=%0d", VEC[r][0]), mx, VEC[r][1]);
            chk(r == 3 ? "R4" : (r == 0 ? "R2" : "R3"), $sformatf("min sel=%0d", VEC[r][0]), mn, VEC[r][2]);
            chk("R5", $sformatf("starts in period sel=%0d", VEC[r][0]), starts, 1);
            chk("R5", $sformatf("start after 1024 sel=%0d", VEC[r][0]), int'(period_start_o), 1);
        end

        // R4: down spread never positive (table row max already 0); spot check peak phase
        fresh_start(3);
        repeat (512) tick();
        chk("R4", "down minimum at phase 512", int'(offset_o), -3750);

        // R9: depth change mid-period
        fresh_start(0);
        repeat (100) tick();
        depth_sel = 2'b10;
        mism = 0;
        for (int p = 100; p < 1024; p++) begin
            if (int'(offset_o) != exp_ofs(0, p)) mism++;
            tick();
        end
        chk("R9", "old depth kept to period end", mism, 0);
        chk("R9", "boundary start", int'(period_start_o), 1);
        repeat (256) tick();
        chk("R9", "new depth peak", int'(offset_o), 2500);

        // R10 / R7: disable latency and hold at zero
        spread_n = 1'b1;
        repeat (2) tick();
        chk("R10", "still on after two edges", int'(spread_on_o), 1);
        tick();
        chk("R10", "off after three edges", int'(spread_on_o), 0);
        chk("R7", "offset zero when off", int'(offset_o), 0);
        mism = 0;
        for (int i = 0; i < 60; i++) begin
            depth_sel = 2'(i % 4);
            tick();
            if (offset_o != 0 || spread_on_o || period_start_o) mism++;
        end
        chk("R7", "outputs idle while disabled", mism, 0);

        // R8: re-enable starts at zero with the last select
        depth_sel = 2'b01;
        repeat (3) tick();
        spread_n = 1'b0;
        repeat (3) tick();
        chk("R8", "restart flag", int'(period_start_o), 1);
        chk("R8", "restart offset", int'(offset_o), 0);
        repeat (768) tick();
        chk("R3", "select 01 negative peak", int'(offset_o), -1250);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule